// File: doc/BRIEF.md
# Two-Channel Digital Volume and Mute Controller

This block scales two streams of signed audio samples (channel A and channel B) by a volume code held for each channel. It can also silence either channel. Each 8-bit code asks for an attenuation of half a decibel per count, so 00h is unity gain and FFh is -127.5 dB. Inside the block, each channel keeps a level index in eighth-decibel units. The value 4·code is the normal target. One further index, MUTE_IDX = 1024, stands for full silence. The block turns the level into a linear gain and multiplies it with every sample. The product is rounded and clamped before it leaves the block.

Level changes follow a three-state machine per channel. The states are SETTLED (level equals target), SLEW (moving without zero-cross gating) and ARMED (a step is pending and waits for a zero crossing). The transitions are:
- SETTLED→SLEW: a change arrives with gating off.
- SETTLED→ARMED: a change arrives with gating on and no crossing.
- SLEW→SETTLED and ARMED→SETTLED: the target is reached.
- ARMED→ARMED: a soft step is taken and more steps remain, or the block keeps waiting.
- SLEW↔ARMED: zero-cross gating is switched mid-change.

A silence watcher per channel counts consecutive zero samples. It forces the channel toward MUTE_IDX once the run is long enough.

Top module: `vm_volume_mute`

## Requirements
- R1: After reset the level is 0 dB, so an input sample leaves unchanged (including -32768 and 32767), and both mute flags and both output strobes are low.
- R2: With soft ramp off, volume code v yields output ≈ round(s·10^(-v/40)), within 2 LSB plus 0.3% of the ideal value per 6 dB of attenuation; code FFh is -127.5 dB.
- R3: With soft ramp off, a new code takes full effect on the next sample. With soft ramp on, the level moves by one eighth-decibel step per sample (zero-cross off), so a one-count change completes over four samples.
- R4: With zero-cross on, a pending level step is applied only on a sample that is zero, or that follows a zero sample, or whose sign bit differs from the previous sample's.
- R5: With zero-cross on and no crossing, the pending step is applied on the 1024th consecutive pending sample.
- R6: With auto_mute_off low (auto-mute active, the default), the 8192nd consecutive zero sample on a channel sets that channel's mute flag.
- R7: The first nonzero sample after auto-mute clears the flag. With soft ramp off, that sample leaves at the programmed level.
- R8: With auto_mute_off high, zero runs never set the mute flag.
- R9: A manual mute (soft ramp off) drives the next output sample to zero and raises the flag. Any output with the flag high is zero.
- R10: With vol_b_follow high, channel B uses vol_a and ignores vol_b.
- R11: Each output strobe is high exactly one cycle after an input strobe and carries that sample's result. Without an input strobe, the level holds.
- R12: The two channels' mutes and silence counters are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_a | input | 1 | Sample strobe, channel A |
| in_sample_a | input | DATA_W | Signed sample, channel A |
| in_valid_b | input | 1 | Sample strobe, channel B |
| in_sample_b | input | DATA_W | Signed sample, channel B |
| vol_a | input | VOL_W | Attenuation code A (0.5 dB/count) |
| vol_b | input | VOL_W | Attenuation code B |
| vol_b_follow | input | 1 | Channel B uses vol_a |
| mute_a | input | 1 | Manual mute A |
| mute_b | input | 1 | Manual mute B |
| soft_en | input | 1 | Eighth-decibel stepping |
| zc_en | input | 1 | Apply steps at zero crossings |
| auto_mute_off | input | 1 | High disables auto-mute |
| out_valid_a | output | 1 | Result strobe A |
| out_sample_a | output | DATA_W | Scaled sample A |
| out_valid_b | output | 1 | Result strobe B |
| out_sample_b | output | DATA_W | Scaled sample B |
| muted_a | output | 1 | Channel A silenced |
| muted_b | output | 1 | Channel B silenced |

## Verification
Auto-mute release and the volume level restore happen in the same cycle. The nonzero sample that ends a zero run also re-targets the level from MUTE_IDX back to the programmed code. That sample is itself scaled by the new level. The bench provokes this with 8192 zero samples followed by one nonzero sample. It then judges that the flag falls and that this very sample leaves unscaled at code 00h, rather than being swallowed at the mute level.

// File: rtl/vm_pkg.sv
package vm_pkg;

    localparam int GAIN_FRAC = 16;
    localparam int GAIN_W    = GAIN_FRAC + 1;
    localparam int OCT_STEPS = 48;
    localparam longint unsigned STEP_COEF = 64'd64600;

    typedef enum logic [1:0] {
        LV_SETTLED,
        LV_SLEW,
        LV_ARMED
    } lvl_state_e;

    typedef logic [OCT_STEPS-1:0][GAIN_W-1:0] frac_tab_t;

    // Gains for one 6 dB band, each entry one eighth-decibel below the last
    function automatic frac_tab_t build_frac_tab();
        frac_tab_t       tab;
        longint unsigned acc;
        acc = 64'd1 << GAIN_FRAC;
        for (int i = 0; i < OCT_STEPS; i++) begin
            tab[i] = acc[GAIN_W-1:0];
            acc    = (acc * STEP_COEF + (64'd1 << (GAIN_FRAC - 1))) >> GAIN_FRAC;
        end
        return tab;
    endfunction

endpackage

// File: rtl/vm_gain_lut.sv
module vm_gain_lut
    import vm_pkg::*;
#(
    parameter int VOL_W = 8
) (
    input  logic [VOL_W+2:0]  level_idx,
    output logic [GAIN_W-1:0] gain
);
    localparam int LVL_W = VOL_W + 3;
    localparam int REM_W = $clog2(OCT_STEPS);
    localparam logic [LVL_W-1:0] MUTE_IDX = LVL_W'(1) << (VOL_W + 2);
    localparam logic [LVL_W-1:0] BAND     = LVL_W'(OCT_STEPS);
    localparam frac_tab_t FRAC = build_frac_tab();

    logic [LVL_W-1:0] band_num;
    logic [LVL_W-1:0] band_rem;

    always_comb begin
        band_num = level_idx / BAND;
        band_rem = level_idx % BAND;
        if (level_idx >= MUTE_IDX) begin
            gain = '0;
        end else begin
            gain = FRAC[band_rem[REM_W-1:0]] >> band_num;
        end
    end
endmodule

// File: rtl/vm_silence_watch.sv
module vm_silence_watch #(
    parameter int DATA_W    = 16,
    parameter int AMUTE_LEN = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    input  logic              watch_off,
    output logic              silent_next,
    output logic              silenced
);
    localparam int CNT_W = $clog2(AMUTE_LEN + 1);
    localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(AMUTE_LEN);

    logic [CNT_W-1:0] run_q, run_d;
    logic             silenced_q;

    always_comb begin
        run_d       = run_q;
        silent_next = silenced_q;
        if (in_valid) begin
            if (in_sample == '0) begin
                run_d = (run_q == RUN_LAST) ? run_q : run_q + CNT_W'(1);
            end else begin
                run_d = '0;
            end
            silent_next = !watch_off && (run_d == RUN_LAST);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= '0;
            silenced_q <= 1'b0;
        end else begin
            run_q      <= run_d;
            silenced_q <= silent_next;
        end
    end

    assign silenced = silenced_q;

    AST_SILENCE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sample != '0) |=> !silenced_q); // R7
    AST_SILENCE_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(silenced_q) |-> $past(in_valid && in_sample == '0)); // R6
    AST_SILENCE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && watch_off) |=> !silenced_q); // R8
endmodule

// File: rtl/vm_level_ctrl.sv
module vm_level_ctrl
    import vm_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int VOL_W      = 8,
    parameter int ZC_TIMEOUT = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic [VOL_W-1:0]         vol_code,
    input  logic                     force_mute,
    input  logic                     soft_en,
    input  logic                     zc_en,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_sample,
    output logic                     at_mute
);
    localparam int LVL_W  = VOL_W + 3;
    localparam int ZC_W   = $clog2(ZC_TIMEOUT);
    localparam int PROD_W = DATA_W + GAIN_W + 1;
    localparam logic [LVL_W-1:0] MUTE_IDX = LVL_W'(1) << (VOL_W + 2);
    localparam logic [ZC_W-1:0]  ZC_LAST  = ZC_W'(ZC_TIMEOUT - 1);
    localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(64'sd1 <<< (GAIN_FRAC - 1));
    localparam logic signed [PROD_W-1:0] SAT_HI   = PROD_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
    localparam logic signed [PROD_W-1:0] SAT_LO   = -SAT_HI - PROD_W'(1);

    lvl_state_e               state_q, state_d;
    logic [LVL_W-1:0]         level_q, level_d, target, step_lvl;
    logic [ZC_W-1:0]          zc_cnt_q, zc_cnt_d;
    logic signed [DATA_W-1:0] prev_q;
    logic                     crossing, gate_open, pending;
    logic [GAIN_W-1:0]        gain;
    logic signed [PROD_W-1:0] prod, rounded;
    logic signed [DATA_W-1:0] out_d, out_q;
    logic                     out_valid_q;

    always_comb begin
        target    = force_mute ? MUTE_IDX : {1'b0, vol_code, 2'b00};
        pending   = (level_q != target);
        crossing  = (prev_q == '0) || (in_sample == '0) ||
                    (prev_q[DATA_W-1] != in_sample[DATA_W-1]);
        gate_open = !zc_en || crossing || (zc_cnt_q == ZC_LAST);
        if (!soft_en) begin
            step_lvl = target;
        end else if (target > level_q) begin
            step_lvl = level_q + LVL_W'(1);
        end else begin
            step_lvl = level_q - LVL_W'(1);
        end
    end

    // Next-state process
    always_comb begin
        state_d  = state_q;
        level_d  = level_q;
        zc_cnt_d = zc_cnt_q;
        if (in_valid) begin
            unique case (state_q)
                LV_SETTLED, LV_SLEW: begin
                    if (pending) begin
                        if (gate_open) level_d = step_lvl;
                        else           zc_cnt_d = ZC_W'(1);
                    end
                end
                LV_ARMED: begin
                    if (!pending) begin
                        zc_cnt_d = '0;
                    end else if (gate_open) begin
                        level_d  = step_lvl;
                        zc_cnt_d = '0;
                    end else begin
                        zc_cnt_d = zc_cnt_q + ZC_W'(1);
                    end
                end
                default: ;
            endcase
            if (level_d == target) state_d = LV_SETTLED;
            else if (zc_en)        state_d = LV_ARMED;
            else                   state_d = LV_SLEW;
            if (state_d != LV_ARMED) zc_cnt_d = '0;
        end
    end

    vm_gain_lut #(.VOL_W(VOL_W)) u_gain (
        .level_idx (level_d),
        .gain      (gain)
    );

    always_comb begin
        prod    = PROD_W'(in_sample) * $signed({1'b0, gain});
        rounded = (prod + HALF_LSB) >>> GAIN_FRAC;
        if (rounded > SAT_HI)      out_d = SAT_HI[DATA_W-1:0];
        else if (rounded < SAT_LO) out_d = SAT_LO[DATA_W-1:0];
        else                       out_d = rounded[DATA_W-1:0];
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= LV_SETTLED;
            level_q     <= '0;
            zc_cnt_q    <= '0;
            prev_q      <= '0;
            out_valid_q <= 1'b0;
            out_q       <= '0;
        end else begin
            state_q     <= state_d;
            level_q     <= level_d;
            zc_cnt_q    <= zc_cnt_d;
            out_valid_q <= in_valid;
            if (in_valid) begin
                prev_q <= in_sample;
                out_q  <= out_d;
            end
        end
    end

    assign out_valid  = out_valid_q;
    assign out_sample = out_q;
    assign at_mute    = (level_q == MUTE_IDX);

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(level_q) && !out_valid_q)); // R11
    AST_SOFT_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && soft_en) |=> ((level_q == $past(level_q)) ||
                                   (level_q == $past(level_q) + LVL_W'(1)) ||
                                   (level_q == $past(level_q) - LVL_W'(1)))); // R3
    AST_ZC_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zc_en && !crossing && zc_cnt_q != ZC_LAST) |=> $stable(level_q)); // R4
endmodule

// File: rtl/vm_volume_mute.sv
module vm_volume_mute
    import vm_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int VOL_W      = 8,
    parameter int ZC_TIMEOUT = 1024,
    parameter int AMUTE_LEN  = 8192
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid_a,
    input  logic signed [DATA_W-1:0] in_sample_a,
    input  logic                     in_valid_b,
    input  logic signed [DATA_W-1:0] in_sample_b,
    input  logic [VOL_W-1:0]         vol_a,
    input  logic [VOL_W-1:0]         vol_b,
    input  logic                     vol_b_follow,
    input  logic                     mute_a,
    input  logic                     mute_b,
    input  logic                     soft_en,
    input  logic                     zc_en,
    input  logic                     auto_mute_off,
    output logic                     out_valid_a,
    output logic signed [DATA_W-1:0] out_sample_a,
    output logic                     out_valid_b,
    output logic signed [DATA_W-1:0] out_sample_b,
    output logic                     muted_a,
    output logic                     muted_b
);
    localparam int NUM_CH = 2;

    logic [NUM_CH-1:0]             ch_valid, ch_man_mute, ch_silent_d, ch_silenced;
    logic [NUM_CH-1:0]             ch_at_mute, ch_out_valid;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_sample, ch_out;
    logic [NUM_CH-1:0][VOL_W-1:0]  ch_vol;

    assign ch_valid    = {in_valid_b, in_valid_a};
    assign ch_sample   = {in_sample_b, in_sample_a};
    assign ch_man_mute = {mute_b, mute_a};
    assign ch_vol[0]   = vol_a;
    assign ch_vol[1]   = vol_b_follow ? vol_a : vol_b;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        vm_silence_watch #(
            .DATA_W    (DATA_W),
            .AMUTE_LEN (AMUTE_LEN)
        ) u_watch (
            .clk         (clk),
            .rst_n       (rst_n),
            .in_valid    (ch_valid[c]),
            .in_sample   (ch_sample[c]),
            .watch_off   (auto_mute_off),
            .silent_next (ch_silent_d[c]),
            .silenced    (ch_silenced[c])
        );

        vm_level_ctrl #(
            .DATA_W     (DATA_W),
            .VOL_W      (VOL_W),
            .ZC_TIMEOUT (ZC_TIMEOUT)
        ) u_level (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_valid   (ch_valid[c]),
            .in_sample  (ch_sample[c]),
            .vol_code   (ch_vol[c]),
            .force_mute (ch_man_mute[c] | ch_silent_d[c]),
            .soft_en    (soft_en),
            .zc_en      (zc_en),
            .out_valid  (ch_out_valid[c]),
            .out_sample (ch_out[c]),
            .at_mute    (ch_at_mute[c])
        );
    end

    assign out_valid_a  = ch_out_valid[0];
    assign out_valid_b  = ch_out_valid[1];
    assign out_sample_a = ch_out[0];
    assign out_sample_b = ch_out[1];
    assign muted_a      = ch_silenced[0] | ch_at_mute[0];
    assign muted_b      = ch_silenced[1] | ch_at_mute[1];

    AST_MUTED_ZERO_A: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_a && muted_a) |-> (out_sample_a == '0)); // R9
    AST_MUTED_ZERO_B: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_b && muted_b) |-> (out_sample_b == '0)); // R9
endmodule

// File: tb/vm_volume_mute_bench.sv
`timescale 1ns/1ps
module vm_volume_mute_bench;
    logic clk = 1'b0;
    logic rst_n;
    logic in_valid_a, in_valid_b;
    logic signed [15:0] in_sample_a, in_sample_b;
    logic [7:0] vol_a, vol_b;
    logic vol_b_follow, mute_a, mute_b, soft_en, zc_en, auto_mute_off;
    logic out_valid_a, out_valid_b, muted_a, muted_b;
    logic signed [15:0] out_sample_a, out_sample_b;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    vm_volume_mute u_vm_volume_mute (
        .clk(clk), .rst_n(rst_n),
        .in_valid_a(in_valid_a), .in_sample_a(in_sample_a),
        .in_valid_b(in_valid_b), .in_sample_b(in_sample_b),
        .vol_a(vol_a), .vol_b(vol_b), .vol_b_follow(vol_b_follow),
        .mute_a(mute_a), .mute_b(mute_b), .soft_en(soft_en), .zc_en(zc_en),
        .auto_mute_off(auto_mute_off),
        .out_valid_a(out_valid_a), .out_sample_a(out_sample_a),
        .out_valid_b(out_valid_b), .out_sample_b(out_sample_b),
        .muted_a(muted_a), .muted_b(muted_b)
    );

    function automatic int ideal(int s, int lvl);
        real g;
        g = 10.0 ** (-lvl / 160.0);
        return $rtoi($floor(s * g + 0.5));
    endfunction

    function automatic int tol_for(int s, int lvl);
        real mag;
        mag = (s < 0 ? -s : s) * (10.0 ** (-lvl / 160.0));
        return $rtoi(2.0 + mag * 0.003 * (lvl / 48.0 + 1.0));
    endfunction

    task automatic check_val(string tag, int act, int exp, int tol);
        int d;
        tests++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (tol %0d)", tag, act, exp, tol);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid_a = 0; in_valid_b = 0; in_sample_a = 0; in_sample_b = 0;
        vol_a = 0; vol_b = 0; vol_b_follow = 0; mute_a = 0; mute_b = 0;
        soft_en = 0; zc_en = 0; auto_mute_off = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(int a, int b);
        in_sample_a = 16'(a);
        in_sample_b = 16'(b);
        in_valid_a  = 1'b1;
        in_valid_b  = 1'b1;
        @(negedge clk);
        in_valid_a  = 1'b0;
        in_valid_b  = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check_val("R1 out_valid_a after reset", out_valid_a, 0, 0);
        check_val("R1 muted_a after reset", muted_a, 0, 0);
        check_val("R1 muted_b after reset", muted_b, 0, 0);
        send(-32768, 32767);
        check_val("R11 out_valid_a after strobe", out_valid_a, 1, 0);
        check_val("R1 unity A", out_sample_a, -32768, 0);
        check_val("R1 unity B", out_sample_b, 32767, 0);
        @(negedge clk);
        check_val("R11 out_valid_a idle", out_valid_a, 0, 0);
    endtask

    task automatic t_levels();
        do_reset();
        vol_a = 8'd12; vol_b = 8'd100;
        send(20000, 32767);
        check_val("R2 code 12", out_sample_a, ideal(20000, 48), tol_for(20000, 48));
        check_val("R2 code 100", out_sample_b, ideal(32767, 400), tol_for(32767, 400));
        vol_a = 8'hFF;
        send(32767, 0);
        check_val("R2 code FF", out_sample_a, ideal(32767, 1020), tol_for(32767, 1020));
    endtask

    task automatic t_soft();
        do_reset();
        vol_a = 8'd1;
        send(20000, 0);
        check_val("R3 hard jump", out_sample_a, ideal(20000, 4), tol_for(20000, 4));
        do_reset();
        soft_en = 1'b1;
        vol_a = 8'd1;
        for (int k = 1; k <= 5; k++) begin
            int lv;
            lv = (k > 4) ? 4 : k;
            send(20000, 0);
            check_val($sformatf("R3 soft step %0d", k), out_sample_a,
                      ideal(20000, lv), tol_for(20000, lv));
        end
    endtask

    task automatic t_zero_cross();
        do_reset();
        zc_en = 1'b1;
        send(1000, 1000);
        vol_a = 8'd20;
        send(1000, 1000);
        check_val("R4 held without crossing", out_sample_a, 1000, 0);
        send(-1000, 1000);
        check_val("R4 applied at crossing", out_sample_a, ideal(-1000, 80), tol_for(-1000, 80));
        send(1000, 1000);
        check_val("R4 level kept", out_sample_a, ideal(1000, 80), tol_for(1000, 80));
        vol_a = 8'd0;
        for (int i = 0; i < 1023; i++) send(1000, 1000);
        check_val("R5 still waiting at 1023", out_sample_a, ideal(1000, 80), tol_for(1000, 80));
        send(1000, 1000);
        check_val("R5 timeout at 1024", out_sample_a, 1000, 0);
    endtask

    task automatic t_auto_mute();
        do_reset();
        for (int i = 0; i < 8191; i++) send(0, 100);
        check_val("R6 not yet muted", muted_a, 0, 0);
        send(0, 100);
        check_val("R6 muted at 8192", muted_a, 1, 0);
        check_val("R12 other channel live", muted_b, 0, 0);
        check_val("R12 other channel output", out_sample_b, 100, 0);
        send(500, 100);
        check_val("R7 flag released", muted_a, 0, 0);
        check_val("R7 release sample passes", out_sample_a, 500, 0);
    endtask

    task automatic t_auto_mute_off();
        do_reset();
        auto_mute_off = 1'b1;
        for (int i = 0; i < 8200; i++) send(0, 0);
        check_val("R8 no mute A", muted_a, 0, 0);
        check_val("R8 no mute B", muted_b, 0, 0);
    endtask

    task automatic t_manual_mute();
        do_reset();
        mute_a = 1'b1;
        send(12345, 12345);
        check_val("R9 muted output", out_sample_a, 0, 0);
        check_val("R9 mute flag", muted_a, 1, 0);
        check_val("R12 B unmuted", out_sample_b, 12345, 0);
        check_val("R12 B flag", muted_b, 0, 0);
        mute_a = 1'b0;
        send(12345, 12345);
        check_val("R9 unmute restores", out_sample_a, 12345, 0);
    endtask

    task automatic t_follow();
        do_reset();
        vol_a = 8'd40; vol_b = 8'd0; vol_b_follow = 1'b1;
        send(10000, 10000);
        check_val("R10 B follows A", out_sample_b, ideal(10000, 160), tol_for(10000, 160));
        vol_b_follow = 1'b0;
        send(10000, 10000);
        check_val("R10 B own code", out_sample_b, 10000, 0);
    endtask

    initial begin
        #500000;
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        t_reset_state();
        t_levels();
        t_soft();
        t_zero_cross();
        t_auto_mute();
        t_auto_mute_off();
        t_manual_mute();
        t_follow();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule